// File: doc/BRIEF.md
# Upstream Pull-up Enable Delay Timer

This block drives the enable for the pull-up resistor on the upstream data-plus line. The enable is held low while the system reset input is asserted. It is also forced low each time the bus-power selector input changes level, in either direction. The enable is released only after a fixed settling delay, 3 ms by default, has run out. A board can therefore switch its power source and have the host see a clean disconnect and reconnect. Resets signalled on the USB data lines have no path into this block and leave the enable untouched.

The selector is an asynchronous board-level input. It passes through a synchroniser chain before any level change is detected. The delay counter's terminal value is worked out at elaboration from a clock-frequency parameter and a delay parameter given in microseconds. With a 48 MHz clock and 3000 µs the terminal value is 144000 cycles.

Top module: `pu_enable_delay`

## Requirements
- R1: While `sys_rst_n` is low, `pu_en` is low in the same cycle, and it stays low during the whole reset.
- R2: After reset is released, `pu_en` goes high on the TC-th rising clock edge at which `sys_rst_n` is sampled high, and not before. TC = CLK_HZ * DELAY_US / 1000000, which is 144000 for the defaults.
- R3: A low-to-high change of `bus_pwr_sel` drives `pu_en` low on the third rising clock edge after the change, and not earlier.
- R4: A high-to-low change of `bus_pwr_sel` drives `pu_en` low on the third rising clock edge after the change, and not earlier.
- R5: After a selector-triggered restart on edge C, `pu_en` stays low through edge C+TC-1 and goes high on edge C+TC.
- R6: Once high, `pu_en` stays high for as long as `sys_rst_n` stays high and `bus_pwr_sel` keeps its level.
- R7: A selector change that arrives while the delay is still running restarts the count from zero. The enable then does not rise at the edge where the original delay would have ended.
- R8: Two selector changes on consecutive cycles (a one-cycle pulse) give a delay that is measured from the later change.
- R9: The level of `bus_pwr_sel` during reset, and any change of it made while reset is asserted, does not lengthen the delay after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock at CLK_HZ |
| sys_rst_n | input | 1 | System reset, active low, sampled on the clock |
| bus_pwr_sel | input | 1 | Bus-power selector level, asynchronous to clk |
| pu_en | output | 1 | Upstream pull-up enable, high once the delay has expired |

## Verification
The bound checker checks the following on every cycle. The enable is low while reset is held. A detected selector change is followed by a low enable. The enable rises only when the counter holds its final value, and it falls only after reset or a detected change. The counter never passes its terminal value. The exact edge counts need the bench's scenarios: the delay after reset, the three-edge latency from a raw selector change, restarts in the middle of a delay, back-to-back changes, and selector activity during reset. Each of these needs a stimulus history that a single-cycle property cannot reconstruct.

// File: rtl/pu_dly_pkg.sv
package pu_dly_pkg;

    // Phase of the delay engine
    typedef enum logic {
        PH_COUNT = 1'b0,
        PH_ON    = 1'b1
    } dly_phase_t;

    // Snapshot of the delay engine handed to the top and the checker
    typedef struct packed {
        dly_phase_t phase;
        logic       restart;
    } dly_ctl_t;

    // Terminal cycle count for a delay in microseconds at a given clock rate
    function automatic longint unsigned term_cycles(
        input longint unsigned clk_hz,
        input longint unsigned delay_us
    );
        longint unsigned n;
        n = (clk_hz * delay_us) / 64'd1_000_000;
        if (n == 0) n = 1;
        return n;
    endfunction

    // Bits needed to hold values 0 .. n-1
    function automatic int unsigned cnt_width(input longint unsigned n);
        int unsigned w;
        w = 1;
        while ((64'd1 << w) < n) w++;
        return w;
    endfunction

endpackage

// File: rtl/pu_dly_sync.sv
module pu_dly_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic chg
);
    // STAGES must be at least 2
    localparam int unsigned MSB = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // First stage samples the asynchronous input
    always_ff @(posedge clk) begin
        chain_q[0] <= din;
    end

    // Remaining stages; during reset they load the raw level so no false edge follows release
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= din;
            else     chain_q[i] <= chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= din;
        else     prev_q <= chain_q[MSB];
    end

    assign chg = chain_q[MSB] ^ prev_q;

endmodule

// File: rtl/pu_dly_counter.sv
module pu_dly_counter
    import pu_dly_pkg::*;
#(
    parameter int unsigned     CNT_W = 18,
    parameter longint unsigned TERM  = 144000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output dly_ctl_t         ctl,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM - 1);

    dly_phase_t phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= PH_COUNT;
            cnt_q   <= '0;
        end else if (phase_q == PH_COUNT) begin
            if (cnt_q == LAST) phase_q <= PH_ON;
            else               cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ctl.phase   = phase_q;
        ctl.restart = restart;
    end

endmodule

// File: rtl/pu_enable_delay.sv
module pu_enable_delay
    import pu_dly_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 48_000_000,
    parameter longint unsigned DELAY_US    = 3000,
    parameter int unsigned     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic bus_pwr_sel,
    output logic pu_en
);
    localparam longint unsigned TERM  = term_cycles(CLK_HZ, DELAY_US);
    localparam int unsigned     CNT_W = cnt_width(TERM);

    logic             rst;
    logic             sel_chg;
    dly_ctl_t         dly_ctl;
    logic [CNT_W-1:0] cnt_q;

    assign rst = ~sys_rst_n;

    pu_dly_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .din(bus_pwr_sel),
        .chg(sel_chg)
    );

    pu_dly_counter #(
        .CNT_W(CNT_W),
        .TERM (TERM)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .restart(sel_chg),
        .ctl    (dly_ctl),
        .cnt_q  (cnt_q)
    );

    // Reset gates the enable directly so it drops in the same cycle
    assign pu_en = (dly_ctl.phase == PH_ON) && sys_rst_n;

endmodule

// File: rtl/pu_enable_delay_chk.sv
module pu_enable_delay_chk
    import pu_dly_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 48_000_000,
    parameter longint unsigned DELAY_US = 3000,
    parameter int unsigned     CNT_W    = 18
) (
    input logic             clk,
    input logic             sys_rst_n,
    input logic             pu_en,
    input logic             sel_chg,
    input logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(term_cycles(CLK_HZ, DELAY_US) - 1);

    // R1
    rst_holds_low_chk: assert property (@(posedge clk) !sys_rst_n |-> !pu_en);

    // R3
    chg_drops_en_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        sel_chg |=> !pu_en);

    // R2
    rise_at_term_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(pu_en) |-> (cnt_q == LAST));

    // R6
    fall_needs_cause_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (pu_en && !sel_chg) |=> pu_en);

    // R5
    no_overrun_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        cnt_q <= LAST);

endmodule

bind pu_enable_delay pu_enable_delay_chk #(
    .CLK_HZ  (CLK_HZ),
    .DELAY_US(DELAY_US),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .sys_rst_n(sys_rst_n),
    .pu_en    (pu_en),
    .sel_chg  (sel_chg),
    .cnt_q    (cnt_q)
);

// File: tb/pu_enable_delay_bench.sv
module pu_enable_delay_bench;
    localparam int TB_HZ = 20000;
    localparam int TB_US = 3000;
    localparam int TC    = TB_HZ * TB_US / 1000000;  // 60 edges
    localparam int NV    = 4;
    localparam int WDOG  = 20000;

    // Vector table: selector level during reset, edges after release before toggle, pulse flag
    localparam logic VLVL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam int   VWAIT[NV] = '{TC + 5, TC + 2, 10, 20};
    localparam logic VPUL [NV] = '{1'b0, 1'b0, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic bus_pwr_sel = 1'b0;
    logic pu_en;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pu_enable_delay #(
        .CLK_HZ  (TB_HZ),
        .DELAY_US(TB_US)
    ) u_pu_enable_delay (
        .clk        (clk),
        .sys_rst_n  (sys_rst_n),
        .bus_pwr_sel(bus_pwr_sel),
        .pu_en      (pu_en)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input logic exp, input string req);
        checks++;
        if (pu_en !== exp) begin
            fails++;
            $display("FAIL %s: pu_en actual=%0b expected=%0b", req, pu_en, exp);
        end
    endtask

    // Each negedge follows one posedge: waiting n negedges lets n rising edges pass
    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        edges(1);
        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = (v == 2) ? "R7" : (v == 3) ? "R8" : "R5";
            sys_rst_n   = 1'b0;
            bus_pwr_sel = VLVL[v];
            edges(3);
            check(1'b0, "R1");
            sys_rst_n = 1'b1;
            if (VWAIT[v] >= TC) begin
                edges(TC - 1);
                check(1'b0, "R2");
                edges(1);
                check(1'b1, VLVL[v] ? "R9" : "R2");
                edges(VWAIT[v] - TC);
                check(1'b1, "R6");
            end else begin
                edges(VWAIT[v]);
                check(1'b0, "R7");
            end
            bus_pwr_sel = ~bus_pwr_sel;
            if (VPUL[v]) begin
                edges(1);
                bus_pwr_sel = ~bus_pwr_sel;
                edges(3);
                check(1'b0, "R8");
            end else if (VWAIT[v] >= TC) begin
                edges(2);
                check(1'b1, VLVL[v] ? "R4" : "R3");
                edges(1);
                check(1'b0, VLVL[v] ? "R4" : "R3");
            end else begin
                edges(3);
                check(1'b0, "R7");
            end
            // Restart edge C has just passed
            edges(TC - 1);
            check(1'b0, rq);
            edges(1);
            check(1'b1, rq);
        end

        // R6: long stable stretch stays high
        for (int i = 0; i < 40; i++) begin
            edges(1);
            check(1'b1, "R6");
        end

        // R1: reset drops the enable within the same cycle
        sys_rst_n = 1'b0;
        #1;
        check(1'b0, "R1");
        edges(2);
        check(1'b0, "R1");

        // R9: selector toggled during reset adds no delay
        bus_pwr_sel = ~bus_pwr_sel;
        edges(2);
        bus_pwr_sel = ~bus_pwr_sel;
        edges(1);
        sys_rst_n = 1'b1;
        edges(TC - 1);
        check(1'b0, "R9");
        edges(1);
        check(1'b1, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule